// File: doc/BRIEF.md
# Divide-by-Twelve Counter with Split Sections

This block is a four-bit counter made of two sections that count on their own and share only a clear. The first section is a single toggle stage, so it divides by two. The second section is a three-bit stage that divides by six. It steps through six codes and never enters the two codes whose lower two bits are both one. Each section has its own count input. A section advances when its count input falls. That falling edge is found by sampling the input in the single system clock and comparing it with the value from the cycle before.

The two sections are joined outside the block to divide by twelve. There are two ways to join them. The first is to feed `q_lo_o` into `tick_hi_i` and apply the incoming pulses to `tick_lo_i`. The outputs then form a four-bit code that skips values 6 and 7. The second is to feed `q_top_o` into `tick_lo_i` and apply the pulses to `tick_hi_i`. Then `q_lo_o` becomes a square wave at one twelfth of the pulse rate. In either chain, the later section updates one system clock after the output that drives it has fallen. The clear takes effect only when both clear inputs are high together.

Top module: `dv12_counter`

## Requirements
- R1: If `clear_x_i` and `clear_y_i` are both 1 at a rising clock edge, all four outputs are 0 after that edge. This holds even when a count input falls in the same cycle.
- R2: If only one of the two clear inputs is 1, counting goes on as if neither were set.
- R3: `q_lo_o` toggles at the first clock edge that samples `tick_lo_i` low after having sampled it high. A rising edge of `tick_lo_i`, or a level held on it, leaves `q_lo_o` unchanged.
- R4: The code {`q_top_o`,`q_mid_o`,`q_bot_o`}, with `q_bot_o` as bit 0, advances once per falling edge of `tick_hi_i`. The order is 000, 001, 010, 100, 101, 110, and then back to 000.
- R5: The codes 011 and 111 never appear on {`q_top_o`,`q_mid_o`,`q_bot_o`}.
- R6: `q_top_o` changes only at the edge where `q_mid_o` goes from 1 to 0, or at a clear.
- R7: With `q_lo_o` wired to `tick_hi_i`, the value {`q_top_o`,`q_mid_o`,`q_bot_o`,`q_lo_o`} after n pulses on `tick_lo_i` is 2*code(floor(n/2)) + (n mod 2). Here code(k) is the k-th entry of the R4 order. The values 6 and 7 never occur, and after 12 pulses the value is 0.
- R8: With `q_top_o` wired to `tick_lo_i`, `q_lo_o` is 1 after pulses 6 to 11 on `tick_hi_i` and 0 after pulses 0 to 5 and after pulse 12.
- R9: While both count inputs stay at a constant level, no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; all state changes on its rising edge |
| clear_x_i | input | 1 | First clear input, active high |
| clear_y_i | input | 1 | Second clear input, active high |
| tick_lo_i | input | 1 | Count input of the divide-by-two section |
| tick_hi_i | input | 1 | Count input of the divide-by-six section |
| q_lo_o | output | 1 | Divide-by-two section output |
| q_bot_o | output | 1 | Divide-by-six section, bit 0 |
| q_mid_o | output | 1 | Divide-by-six section, bit 1 |
| q_top_o | output | 1 | Divide-by-six section, bit 2; completes one period per six input pulses |

## Verification
A bad state in the divide-by-six section appears on the ports at the next falling count edge. That edge either produces a skipped code or steps out of the six-code order. A stuck toggle stage shows up after a single pulse. A missed or extra falling-edge detection shifts every later value, so a reference model compared on every clock catches it within the same cycle. In the chained set-ups, an error in the first section moves the second section by one step within one clock of the next edge on the joining wire.

// File: rtl/dv12_pkg.sv
package dv12_pkg;

    localparam int SIX_W = 3;

    typedef struct packed {
        logic top;
        logic mid;
        logic bot;
    } six_state_t;

    localparam six_state_t SIX_ZERO = '0;

    // mod-3 pair on {mid,bot}; top flips when mid falls
    function automatic six_state_t six_step(input six_state_t s);
        six_state_t n;
        unique case ({s.mid, s.bot})
            2'b00:   {n.mid, n.bot} = 2'b01;
            2'b01:   {n.mid, n.bot} = 2'b10;
            default: {n.mid, n.bot} = 2'b00;
        endcase
        n.top = s.top ^ (s.mid & ~n.mid);
        return n;
    endfunction

endpackage

// File: rtl/dv12_fall_detect.sv
module dv12_fall_detect (
    input  logic clk_i,
    input  logic clr_i,
    input  logic sig_i,
    output logic fall_o
);
    typedef struct packed {
        logic prev;
    } fd_reg_t;

    fd_reg_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.prev = clr_i ? 1'b0 : sig_i;
    end

    always_ff @(posedge clk_i) begin
        r_q <= r_d;
    end

    assign fall_o = r_q.prev & ~sig_i;

endmodule

// File: rtl/dv12_half_stage.sv
module dv12_half_stage (
    input  logic clk_i,
    input  logic clr_i,
    input  logic adv_i,
    output logic q_o
);
    typedef struct packed {
        logic q;
    } hs_reg_t;

    hs_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clr_i)
            r_d.q = 1'b0;
        else if (adv_i)
            r_d.q = ~r_q.q;
    end

    always_ff @(posedge clk_i) begin
        r_q <= r_d;
    end

    assign q_o = r_q.q;

    // R3: without an advance request the stage holds
    a_r3_hold_without_edge: assert property (@(posedge clk_i) disable iff (clr_i)
        (!$past(clr_i) && !$past(adv_i)) |-> $stable(q_o));

    // R3: an advance request always flips the stage
    a_r3_flip_on_edge: assert property (@(posedge clk_i) disable iff (clr_i)
        (!$past(clr_i) && $past(adv_i)) |-> (q_o != $past(q_o)));

endmodule

// File: rtl/dv12_six_stage.sv
module dv12_six_stage
    import dv12_pkg::*;
(
    input  logic             clk_i,
    input  logic             clr_i,
    input  logic             adv_i,
    output logic [SIX_W-1:0] st_o
);
    typedef struct packed {
        six_state_t st;
    } ss_reg_t;

    ss_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clr_i)
            r_d.st = SIX_ZERO;
        else if (adv_i)
            r_d.st = six_step(r_q.st);
    end

    always_ff @(posedge clk_i) begin
        r_q <= r_d;
    end

    assign st_o = r_q.st;

    // R5: lower pair never reaches 11
    a_r5_no_skipped_code: assert property (@(posedge clk_i) disable iff (clr_i)
        !(st_o[1] && st_o[0]));

    // R6: top bit moves exactly when mid falls
    a_r6_top_follows_mid_fall: assert property (@(posedge clk_i) disable iff (clr_i)
        !$past(clr_i) |-> ((st_o[2] != $past(st_o[2])) == (!st_o[1] && $past(st_o[1]))));

    // R4: the stage moves only on an advance request
    a_r4_hold_without_edge: assert property (@(posedge clk_i) disable iff (clr_i)
        (!$past(clr_i) && !$past(adv_i)) |-> $stable(st_o));

endmodule

// File: rtl/dv12_counter.sv
module dv12_counter
    import dv12_pkg::*;
(
    input  logic clk_i,
    input  logic clear_x_i,
    input  logic clear_y_i,
    input  logic tick_lo_i,
    input  logic tick_hi_i,
    output logic q_lo_o,
    output logic q_bot_o,
    output logic q_mid_o,
    output logic q_top_o
);
    logic             clr;
    logic             fall_lo;
    logic             fall_hi;
    logic [SIX_W-1:0] six_st;

    assign clr = clear_x_i & clear_y_i;

    dv12_fall_detect u_fd_lo (
        .clk_i  (clk_i),
        .clr_i  (clr),
        .sig_i  (tick_lo_i),
        .fall_o (fall_lo)
    );

    dv12_fall_detect u_fd_hi (
        .clk_i  (clk_i),
        .clr_i  (clr),
        .sig_i  (tick_hi_i),
        .fall_o (fall_hi)
    );

    dv12_half_stage u_half (
        .clk_i (clk_i),
        .clr_i (clr),
        .adv_i (fall_lo),
        .q_o   (q_lo_o)
    );

    dv12_six_stage u_six (
        .clk_i (clk_i),
        .clr_i (clr),
        .adv_i (fall_hi),
        .st_o  (six_st)
    );

    assign q_bot_o = six_st[0];
    assign q_mid_o = six_st[1];
    assign q_top_o = six_st[2];

    // R1: joint clear empties every output on the next edge
    a_r1_clear_all: assert property (@(posedge clk_i)
        (clear_x_i && clear_y_i) |=> !(q_lo_o || q_bot_o || q_mid_o || q_top_o));

    // R9: steady count inputs leave outputs alone
    a_r9_idle_stable: assert property (@(posedge clk_i) disable iff (clr)
        (!$past(clr) && $stable(tick_lo_i) && $stable(tick_hi_i)
         && $past(tick_lo_i) == $past(tick_lo_i, 2) && $past(tick_hi_i) == $past(tick_hi_i, 2)
         && !$past(clr, 2))
        |=> $stable({q_lo_o, q_top_o, q_mid_o, q_bot_o}));

endmodule

// File: tb/dv12_counter_tb.sv
module dv12_counter_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic cx = 1'b1, cy = 1'b1;
    logic drv_lo = 1'b0, drv_hi = 1'b0;
    int   mode = 0; // 0 free, 1 lo->hi chain, 2 hi->lo chain
    logic tick_lo, tick_hi;
    logic q_lo, q_bot, q_mid, q_top;

    int checks = 0, errors = 0;
    bit chk_on = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign tick_lo = (mode == 2) ? q_top : drv_lo;
    assign tick_hi = (mode == 1) ? q_lo  : drv_hi;

    dv12_counter dut_i (
        .clk_i     (clk),
        .clear_x_i (cx),
        .clear_y_i (cy),
        .tick_lo_i (tick_lo),
        .tick_hi_i (tick_hi),
        .q_lo_o    (q_lo),
        .q_bot_o   (q_bot),
        .q_mid_o   (q_mid),
        .q_top_o   (q_top)
    );

    function automatic int six_code(input int k);
        return (k < 3) ? k : k + 1;
    endfunction

    // behavioural reference
    int m_half = 0, m_six = 0;
    bit m_prev_lo = 0, m_prev_hi = 0;
    bit m_lo_now, m_hi_now;
    bit e_lo, e_top;

    always @(posedge clk) begin
        e_lo  = m_half[0];
        e_top = six_code(m_six) >= 4;
        m_lo_now = (mode == 2) ? e_top : drv_lo;
        m_hi_now = (mode == 1) ? e_lo  : drv_hi;
        if (cx && cy) begin
            m_half = 0; m_six = 0; m_prev_lo = 0; m_prev_hi = 0;
        end else begin
            if (m_prev_lo && !m_lo_now) m_half = 1 - m_half;
            if (m_prev_hi && !m_hi_now) m_six = (m_six + 1) % 6;
            m_prev_lo = m_lo_now;
            m_prev_hi = m_hi_now;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on) begin
            check(q_lo == m_half[0], "R3 model q_lo", q_lo, m_half);
            check({q_top, q_mid, q_bot} == 3'(six_code(m_six)), "R4 model code",
                  {q_top, q_mid, q_bot}, six_code(m_six));
            check(!(q_mid && q_bot), "R5 skipped code", {q_top, q_mid, q_bot}, 0);
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_lo();
        drv_lo = 1'b1; cyc(2); drv_lo = 1'b0; cyc(3);
    endtask

    task automatic pulse_hi();
        drv_hi = 1'b1; cyc(2); drv_hi = 1'b0; cyc(3);
    endtask

    task automatic do_clear();
        cx = 1'b1; cy = 1'b1; cyc(2); cx = 1'b0; cy = 1'b0; cyc(1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog all-reqs actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int v, e;
        logic [3:0] snap;
        cyc(3);
        cx = 1'b0; cy = 1'b0;
        cyc(1);
        chk_on = 1;
        check({q_lo, q_top, q_mid, q_bot} == 4'b0, "R1 reset state", {q_lo, q_top, q_mid, q_bot}, 0);

        // R3: rise alone does nothing, fall toggles
        drv_lo = 1'b1; cyc(3);
        check(q_lo == 1'b0, "R3 rise ignored", q_lo, 0);
        drv_lo = 1'b0; cyc(1);
        check(q_lo == 1'b1, "R3 fall toggles", q_lo, 1);
        pulse_lo();
        check(q_lo == 1'b0, "R3 second fall", q_lo, 0);

        // R4 / R6 order on the six stage
        for (int k = 1; k <= 7; k++) begin
            pulse_hi();
            e = six_code(k % 6);
            check({q_top, q_mid, q_bot} == 3'(e), "R4 order", {q_top, q_mid, q_bot}, e);
            check(q_top == (e >= 4), "R6 top bit", q_top, e >= 4);
        end

        // R9: idle inputs at both levels
        snap = {q_lo, q_top, q_mid, q_bot};
        drv_hi = 1'b1; cyc(2); snap = {q_lo, q_top, q_mid, q_bot};
        cyc(20);
        check({q_lo, q_top, q_mid, q_bot} == snap, "R9 idle high", {q_lo, q_top, q_mid, q_bot}, snap);
        drv_hi = 1'b0; cyc(2);
        snap = {q_lo, q_top, q_mid, q_bot};
        cyc(20);
        check({q_lo, q_top, q_mid, q_bot} == snap, "R9 idle low", {q_lo, q_top, q_mid, q_bot}, snap);

        // R2: a single clear input does not clear
        cx = 1'b1;
        snap = {q_lo, q_top, q_mid, q_bot};
        cyc(3);
        check({q_lo, q_top, q_mid, q_bot} == snap, "R2 one clear holds", {q_lo, q_top, q_mid, q_bot}, snap);
        pulse_lo();
        check(q_lo != snap[3], "R2 counting with one clear", q_lo, !snap[3]);
        cx = 1'b0; cy = 1'b1;
        pulse_hi();
        check({q_top, q_mid, q_bot} != snap[2:0], "R2 six stage with other clear",
              {q_top, q_mid, q_bot}, snap[2:0]);
        cy = 1'b0;

        // R1: clear wins over a falling edge in the same cycle
        drv_lo = 1'b1; drv_hi = 1'b1; cyc(2);
        drv_lo = 1'b0; drv_hi = 1'b0; cx = 1'b1; cy = 1'b1; cyc(1);
        check({q_lo, q_top, q_mid, q_bot} == 4'b0, "R1 clear priority", {q_lo, q_top, q_mid, q_bot}, 0);
        cx = 1'b0; cy = 1'b0; cyc(2);
        check({q_lo, q_top, q_mid, q_bot} == 4'b0, "R1 no late edge", {q_lo, q_top, q_mid, q_bot}, 0);

        // R7: low section drives high section
        mode = 1; do_clear();
        for (int n = 1; n <= 12; n++) begin
            pulse_lo();
            v = {q_top, q_mid, q_bot, q_lo};
            e = 2 * six_code((n / 2) % 6) + (n % 2);
            check(v == e, "R7 chain value", v, e);
            check(v != 6 && v != 7, "R7 skips 6 and 7", v, e);
        end
        check({q_top, q_mid, q_bot, q_lo} == 4'b0, "R7 wrap after 12", {q_top, q_mid, q_bot, q_lo}, 0);

        // R8: high section drives low section
        mode = 2; do_clear();
        for (int n = 1; n <= 12; n++) begin
            pulse_hi();
            e = (n >= 6 && n < 12) ? 1 : 0;
            check(q_lo == e, "R8 square output", q_lo, e);
        end

        mode = 0; cyc(2);
        chk_on = 0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule